// File: doc/BRIEF.md
# Bottling Line Sequencer with Suspend Memory

This block drives one filling station from four level inputs: a start enable, a suspend request, a bottle-in-place contact and a bottle-full signal from the scale. It produces three actuator levels: the supply gate, the conveyor motor and the fill valve. The controller is a Moore machine held in four flip-flops. The top flag separates the blocked mode from the running modes. The second flag marks suspension. The two low bits name the working phase: idle, gate open, moving or filling.

The controller advances on every clock. A suspend request raises the suspension flag and leaves the phase bits untouched. Releasing the request therefore returns the line to the exact phase that was interrupted. Two counters are each tied to one phase. One sets the length of the gate pulse. The other limits how long the valve may stay open before the line is declared faulty. Both lengths are parameters given in clock ticks. All pins are plain levels sampled on the rising edge. There is no data stream, so there is no handshake.

Top module: `bottle_line_ctrl`

## Requirements
- R1: After reset the state code `state_bits` is 4'b0000 (blocked), and all three actuator outputs are low.
- R2: The actuators are decoded only from the state code, where bit 3 is the run flag, bit 2 the suspension flag and bits 1:0 the phase. `gate_open` is high only in 4'b1001 (gate phase). `conveyor_on` is high in 4'b1001 and 4'b1011 (moving phase). `valve_open` is high only in 4'b1010 (filling phase). Every other code drives all three low.
- R3: While blocked (bit 3 low), a high `start_en` moves the controller to idle (4'b1000). A low `start_en` leaves it blocked.
- R4: In idle (4'b1000) with `start_en` high, `hold_req` low and `bottle_ready` low, the next state is the gate phase (4'b1001). With `bottle_ready` high the controller stays idle.
- R5: In any working phase with `start_en` high, a high `hold_req` sets bit 2 and keeps bits 1:0. While `hold_req` stays high the state does not change, whatever `bottle_ready` and `bottle_full` do.
- R6: When suspended and `hold_req` is low, the next state clears bit 2 and keeps bits 1:0, which resumes the interrupted phase.
- R7: With `hold_req` low throughout, the gate phase lasts exactly GATE_TICKS cycles and is then followed by the moving phase (4'b1011).
- R8: In the moving phase, `bottle_ready` high moves the controller to filling (4'b1010). `bottle_ready` low keeps it moving.
- R9: In the filling phase with `hold_req` low, the following apply. `bottle_ready` and `bottle_full` both high lead to idle, and this also holds in the final allowed cycle. `bottle_ready` low leads to blocked. Otherwise, after FILL_TICKS cycles in the phase the controller moves to blocked.
- R10: A low `start_en` in any working phase (bit 3 high, bit 2 low) forces blocked on the next cycle. This takes priority over `hold_req`.
- R11: The phase counters restart from zero whenever their phase is re-entered, including a resume from suspension. A gate phase resumed after a suspend therefore again lasts GATE_TICKS cycles.
- R12: While suspended, `start_en` has no effect. Only the release of `hold_req` changes the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one tick of both phase counters |
| rst_n | input | 1 | Asynchronous active-low reset into blocked |
| start_en | input | 1 | Level enable for running the line |
| hold_req | input | 1 | Level request to suspend the current phase |
| bottle_ready | input | 1 | Bottle sits on the platform contact |
| bottle_full | input | 1 | Scale reports the bottle full |
| gate_open | output | 1 | Supply gate actuator |
| conveyor_on | output | 1 | Conveyor motor actuator |
| valve_open | output | 1 | Fill valve actuator |
| state_bits | output | 4 | Current state code {run, suspend, phase[1:0]} |

## Verification
The bench counts gate cycles exactly, including a gate phase interrupted partway through and resumed. A counter that is not cleared during suspension would cut the resumed pulse short. The filling timeout is probed at its last cycle with completion arriving at the same moment. A design that gives the timeout priority would block a bottle that is full. The suspend tests toggle the bottle inputs and drop the start enable while suspended. A design that lost the phase bits, or that let those inputs act during the hold, would resume into the wrong phase or fall into blocked too early. Dropping the start enable together with a suspend request checks that the fault path wins over suspension.

// File: rtl/blc_pkg.sv
package blc_pkg;
  typedef logic [3:0] blc_state_t;

  // {run, suspend, phase[1:0]}
  localparam blc_state_t ST_BLOCKED = 4'b0000;
  localparam blc_state_t ST_IDLE    = 4'b1000;
  localparam blc_state_t ST_GATE    = 4'b1001;
  localparam blc_state_t ST_MOVE    = 4'b1011;
  localparam blc_state_t ST_FILL    = 4'b1010;

  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_GATE = 2'b01;
  localparam logic [1:0] PH_MOVE = 2'b11;
  localparam logic [1:0] PH_FILL = 2'b10;

  localparam int RUN_BIT = 3;
  localparam int SUS_BIT = 2;
endpackage

// File: rtl/blc_phase_timer.sv
module blc_phase_timer #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  // counts while its phase is current, saturates on the last tick,
  // and clears on any cycle the phase is not current
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!active)    cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = active && (cnt == LAST);

  // R11: a counter left idle for a cycle starts again from zero
  a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0));
endmodule

// File: rtl/blc_next_state.sv
module blc_next_state
  import blc_pkg::*;
(
  input  blc_state_t cur,
  input  logic       start_en,
  input  logic       hold_req,
  input  logic       bottle_ready,
  input  logic       bottle_full,
  input  logic       gate_done,
  input  logic       fill_timeout,
  output blc_state_t nxt
);
  logic [1:0] phase;
  assign phase = cur[1:0];

  always_comb begin
    nxt = cur;
    if (!cur[RUN_BIT]) begin
      if (start_en) nxt = ST_IDLE;
    end else if (cur[SUS_BIT]) begin
      if (!hold_req) nxt = {2'b10, phase};
    end else if (!start_en) begin
      nxt = ST_BLOCKED;
    end else if (hold_req) begin
      nxt = {2'b11, phase};
    end else begin
      unique case (phase)
        PH_IDLE: if (!bottle_ready) nxt = ST_GATE;
        PH_GATE: if (gate_done)     nxt = ST_MOVE;
        PH_MOVE: if (bottle_ready)  nxt = ST_FILL;
        PH_FILL: begin
          if (bottle_ready && bottle_full) nxt = ST_IDLE;
          else if (!bottle_ready)          nxt = ST_BLOCKED;
          else if (fill_timeout)           nxt = ST_BLOCKED;
        end
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/bottle_line_ctrl.sv
module bottle_line_ctrl
  import blc_pkg::*;
#(
  parameter int GATE_TICKS = 3,
  parameter int FILL_TICKS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_en,
  input  logic       hold_req,
  input  logic       bottle_ready,
  input  logic       bottle_full,
  output logic       gate_open,
  output logic       conveyor_on,
  output logic       valve_open,
  output logic [3:0] state_bits
);
  blc_state_t st, st_nxt;
  logic gate_done, fill_timeout;

  // counters are evaluated from the current state, ahead of the update
  blc_phase_timer #(.LEN(GATE_TICKS)) u_gate_tmr (
    .clk(clk), .rst_n(rst_n), .active(st == ST_GATE), .expired(gate_done));

  blc_phase_timer #(.LEN(FILL_TICKS)) u_fill_tmr (
    .clk(clk), .rst_n(rst_n), .active(st == ST_FILL), .expired(fill_timeout));

  blc_next_state u_nxt (
    .cur(st), .start_en(start_en), .hold_req(hold_req),
    .bottle_ready(bottle_ready), .bottle_full(bottle_full),
    .gate_done(gate_done), .fill_timeout(fill_timeout), .nxt(st_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_BLOCKED;
    else        st <= st_nxt;
  end

  assign gate_open   = (st == ST_GATE);
  assign conveyor_on = (st == ST_GATE) || (st == ST_MOVE);
  assign valve_open  = (st == ST_FILL);
  assign state_bits  = st;

  // R2: valve and conveyor never run together; gate implies conveyor
  a_r2_actuator_mix: assert property (@(posedge clk) disable iff (!rst_n)
    !(valve_open && conveyor_on) && (!gate_open || conveyor_on));

  // R3: blocked with start enable goes to idle
  a_r3_wake_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!st[RUN_BIT] && start_en) |=> (state_bits == ST_IDLE));

  // R5: state is frozen while a suspend request is held
  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st[RUN_BIT] && st[SUS_BIT] && hold_req) |=> $stable(state_bits));

  // R6: release returns to the recorded phase
  a_r6_resume_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (st[RUN_BIT] && st[SUS_BIT] && !hold_req) |=>
      (state_bits == {2'b10, $past(state_bits[1:0])}));

  // R10: start enable dropped in a working phase forces blocked
  a_r10_start_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (st[RUN_BIT] && !st[SUS_BIT] && !start_en) |=> (state_bits == ST_BLOCKED));
endmodule

// File: tb/bottle_line_ctrl_test.sv
module bottle_line_ctrl_test;
  localparam int GT = 3;
  localparam int FT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s = 1'b0, p = 1'b0, r = 1'b0, f = 1'b0;
  logic g, t, z;
  logic [3:0] sb;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bottle_line_ctrl #(.GATE_TICKS(GT), .FILL_TICKS(FT)) uut (
    .clk(clk), .rst_n(rst_n), .start_en(s), .hold_req(p),
    .bottle_ready(r), .bottle_full(f), .gate_open(g), .conveyor_on(t),
    .valve_open(z), .state_bits(sb));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic vs, input logic vp, input logic vr, input logic vf);
    s = vs; p = vp; r = vr; f = vf;
    tick();
  endtask

  task automatic chk(input string req, input logic [3:0] exp_st, input logic [2:0] exp_out);
    n_chk++;
    if (sb !== exp_st || {g, t, z} !== exp_out) begin
      n_bad++;
      $display("FAIL %s: state=%b gtz=%b expected state=%b gtz=%b", req, sb, {g, t, z}, exp_st, exp_out);
    end
  endtask

  task automatic to_idle();
    rst_n = 1'b0; s = 0; p = 0; r = 0; f = 0;
    tick(); rst_n = 1'b1; tick();
    drive(1, 0, 1, 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; tick();
    chk("R1 reset", 4'b0000, 3'b000);
    rst_n = 1'b1; tick();
    drive(0, 0, 0, 0);
    chk("R3 stays blocked", 4'b0000, 3'b000);
    drive(1, 0, 1, 0);
    chk("R3 wake", 4'b1000, 3'b000);
    drive(1, 0, 1, 0);
    chk("R4 bottle present holds idle", 4'b1000, 3'b000);
  endtask

  task automatic test_cycle();
    to_idle();
    drive(1, 0, 0, 0);
    for (int i = 0; i < GT; i++) begin
      chk("R7 gate pulse R2", 4'b1001, 3'b110);
      tick();
    end
    chk("R7 to moving", 4'b1011, 3'b010);
    drive(1, 0, 0, 0);
    chk("R8 waits", 4'b1011, 3'b010);
    drive(1, 0, 1, 0);
    chk("R8 to filling", 4'b1010, 3'b001);
    drive(1, 0, 1, 1);
    chk("R9 full to idle", 4'b1000, 3'b000);
  endtask

  task automatic test_fill_faults();
    to_idle();
    drive(1, 0, 0, 0);
    repeat (GT) tick();
    drive(1, 0, 1, 0);
    drive(1, 0, 0, 0);
    chk("R9 bottle removed", 4'b0000, 3'b000);
    to_idle();
    drive(1, 0, 0, 0);
    repeat (GT) tick();
    drive(1, 0, 1, 0);
    for (int i = 0; i < FT; i++) begin
      chk("R9 valve during fill", 4'b1010, 3'b001);
      tick();
    end
    chk("R9 timeout", 4'b0000, 3'b000);
    to_idle();
    drive(1, 0, 0, 0);
    repeat (GT) tick();
    drive(1, 0, 1, 0);
    repeat (FT - 1) tick();
    chk("R9 last fill cycle", 4'b1010, 3'b001);
    drive(1, 0, 1, 1);
    chk("R9 full wins at timeout", 4'b1000, 3'b000);
  endtask

  task automatic test_suspend();
    to_idle();
    drive(1, 0, 0, 0);
    repeat (GT) tick();
    drive(1, 1, 0, 0);
    chk("R5 suspend moving", 4'b1111, 3'b000);
    drive(1, 1, 1, 1);
    chk("R5 inputs ignored", 4'b1111, 3'b000);
    drive(0, 1, 1, 0);
    chk("R12 start ignored", 4'b1111, 3'b000);
    drive(1, 0, 0, 0);
    chk("R6 resume moving", 4'b1011, 3'b010);
    to_idle();
    drive(1, 0, 0, 0);
    tick();
    drive(1, 1, 0, 0);
    chk("R5 suspend gate", 4'b1101, 3'b000);
    drive(1, 0, 0, 0);
    for (int i = 0; i < GT; i++) begin
      chk("R11 full pulse after resume", 4'b1001, 3'b110);
      tick();
    end
    chk("R11 moving after pulse", 4'b1011, 3'b010);
  endtask

  task automatic test_start_drop();
    to_idle();
    drive(1, 0, 0, 0);
    repeat (GT) tick();
    drive(0, 0, 0, 0);
    chk("R10 drop in moving", 4'b0000, 3'b000);
    to_idle();
    drive(0, 1, 0, 0);
    chk("R10 beats suspend", 4'b0000, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick();
    test_reset();
    test_cycle();
    test_fill_faults();
    test_suspend();
    test_start_drop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule